// File: doc/BRIEF.md
# Low-Speed Oscillator Control and Reset-Cause Register

This block is one 32-bit control/status register. It drives a low-speed external crystal oscillator and keeps a record of why the chip last reset. Software reaches it over a simple select/write bus with byte-lane strobes.

The register drives four things to the oscillator:
- an enable,
- a bypass control,
- a two-bit crystal drive strength,
- an enable for the internal low-speed RC oscillator.

It reports two ready indications back to the bus clock domain. Each one passes through a two-flop synchronizer.

When the external oscillator is switched off, its ready flag does not drop at once. It falls a fixed number of cycles later, and those cycles are counted on the slow oscillator clock. The bypass control is locked while the oscillator is on or still ready.

Reset-cause pulses from the reset controller set sticky flags in the top bits. These flags live in the power-on reset domain, so a system reset leaves them intact. All control fields clear on a system reset. Software clears every cause flag at once through a write-one clear bit, and a cause pulse that arrives in the same cycle as the clear still sets its flag.

Top module: `osc_rst_csr`

## Requirements
- R1: After power-on reset, the register reads 0x0C000000: brown-out flag bit 27 and pin flag bit 26 are set, and everything else is zero. The xo_en, xo_bypass, xo_drive and lsi_en outputs are all 0.
- R2: A system reset (rst_n low, por_n high) clears every control field and output but leaves the reset-cause flags in bits 31:25 unchanged.
- R3: Bit 0 is the read/write external oscillator enable and drives xo_en. Bit 8 is the read/write internal oscillator enable and drives lsi_en.
- R4: Bits 4:3 are the read/write drive strength, 00 lowest to 11 highest, and drive xo_drive.
- R5: Bit 2 (bypass, drives xo_bypass) takes a written value only when, at the time of the write, the enable is 0 and the ready flag is 0. Otherwise the write leaves it unchanged.
- R6: Bit 1 is a read-only ready flag. It follows osc_stable while the oscillator is enabled. After the enable is cleared, it stays set for 6 slow_clk cycles before falling.
- R7: Each rst_cause pulse sets a sticky flag, and the flag holds until it is cleared. The mapping is rst_cause[6:0] to bits 31:25, in this order: low-power, window watchdog, independent watchdog, software, brown-out, pin, option load.
- R8: Writing 1 to bit 23 (with byte lane 2 strobed) clears all cause flags, and bit 23 reads 0. A pulse in the same cycle as the clear leaves its flag set.
- R9: Only byte lanes whose bus_strb bit is 1 are written. Data in an unstrobed lane, including bit 23, has no effect.
- R10: Reserved bits read 0 and ignore writes. Writes to the ready bits 1 and 9 and to the cause flags have no effect.
- R11: An access completes in its first cycle unless an access completed in the previous cycle. In that case bus_ready is held low for exactly 2 cycles first.
- R12: Bit 9 is a read-only internal oscillator ready flag that reflects lsi_stable after two bus-clock flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | System reset, active low, asynchronous assert |
| por_n | input | 1 | Power-on reset, active low; clears the cause flags |
| slow_clk | input | 1 | Slow external oscillator clock |
| bus_sel | input | 1 | Access request, held until bus_ready |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_strb | input | 4 | Byte-lane write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when not selected |
| bus_ready | output | 1 | Access completes in this cycle |
| osc_stable | input | 1 | External oscillator stable, slow_clk domain |
| lsi_stable | input | 1 | Internal oscillator stable |
| rst_cause | input | 7 | Reset-cause pulses, bus clock domain |
| xo_en | output | 1 | External oscillator enable |
| xo_bypass | output | 1 | External oscillator bypass |
| xo_drive | output | 2 | Crystal drive strength |
| lsi_en | output | 1 | Internal oscillator enable |

## Verification
The bench uses the default parameters:
- a fall delay of 6 slow cycles,
- 2 wait states,
- 7 cause flags with brown-out and pin set at power-on.

With these values, the whole flag field and the full ready-flag timing window can be reached in a short run. The slow clock runs at one eighth of the bus clock. This places the bypass-lock test inside the gap between clearing the enable and the ready flag falling, and the later release of the lock well after it.

// File: rtl/osc_csr_pkg.sv
package osc_csr_pkg;
  localparam int unsigned DW       = 32;
  localparam int unsigned NLANE    = DW / 8;
  localparam int unsigned BIT_EN   = 0;
  localparam int unsigned BIT_RDY  = 1;
  localparam int unsigned BIT_BYP  = 2;
  localparam int unsigned DRV_LO   = 3;
  localparam int unsigned BIT_LEN  = 8;
  localparam int unsigned BIT_LRDY = 9;
  localparam int unsigned BIT_CLR  = 23;

  typedef struct packed {
    logic       en;
    logic       byp;
    logic [1:0] drv;
    logic       lsi_en;
  } ctl_t;

  localparam ctl_t CTL_RST = '0;
endpackage

// File: rtl/osc_csr_sync2.sv
module osc_csr_sync2 #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/osc_csr_rdy_timer.sv
module osc_csr_rdy_timer #(
  parameter int unsigned DROP_CYC = 6
) (
  input  logic slow_clk,
  input  logic rst_n,
  input  logic en_bus,
  input  logic osc_stable,
  output logic rdy_slow
);
  localparam int unsigned CW = $clog2(DROP_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(DROP_CYC - 1);

  logic          en_s;
  logic          rdy_q, rdy_d;
  logic [CW-1:0] cnt_q, cnt_d;

  osc_csr_sync2 #(.W(1)) i_en_sync (
    .clk(slow_clk), .rst_n(rst_n), .d(en_bus), .q(en_s)
  );

  always_comb begin
    rdy_d = rdy_q;
    cnt_d = cnt_q;
    if (en_s) begin
      rdy_d = osc_stable;
      cnt_d = '0;
    end else if (rdy_q) begin
      if (cnt_q == LAST) begin
        rdy_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge slow_clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      rdy_q <= rdy_d;
      cnt_q <= cnt_d;
    end
  end

  assign rdy_slow = rdy_q;

  // R6: ready only rises from an enabled, stable oscillator
  p_rise_enabled_r6: assert property (@(posedge slow_clk) disable iff (!rst_n)
    $rose(rdy_q) |-> ($past(en_s) && $past(osc_stable)));
  // R6: after disable, ready falls only once the full count has elapsed
  p_fall_late_r6: assert property (@(posedge slow_clk) disable iff (!rst_n)
    ($fell(rdy_q) && !$past(en_s)) |-> ($past(cnt_q) == LAST));
endmodule

// File: rtl/osc_csr_cause.sv
module osc_csr_cause #(
  parameter int unsigned N       = 7,
  parameter logic [N-1:0] POR_VAL = '0
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [N-1:0] pulse,
  input  logic         clr,
  output logic [N-1:0] flags
);
  logic [N-1:0] flg_q, flg_d;
  logic         flg_ce;

  assign flg_ce = clr | (|pulse);

  always_comb begin
    flg_d = (flg_q & ~{N{clr}}) | pulse;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      flg_q <= POR_VAL;
    else if (flg_ce) flg_q <= flg_d;
  end

  assign flags = flg_q;

  // R8: a pulse sets its flag even against a simultaneous clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!por_n)
    (|pulse) |=> ((flags & $past(pulse)) == $past(pulse)));
  // R7: without a clear, no flag ever drops
  p_flag_hold_r7: assert property (@(posedge clk) disable iff (!por_n)
    !clr |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/osc_csr_bus_wait.sv
module osc_csr_bus_wait #(
  parameter int unsigned WAIT_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  output logic ready
);
  localparam int unsigned WW = (WAIT_CYC < 1) ? 1 : $clog2(WAIT_CYC + 1);
  localparam logic [WW-1:0] WLIM = WW'(WAIT_CYC);

  logic [WW-1:0] ws_q, ws_d;
  logic          done_q, done_d;
  logic          need_wait;

  assign need_wait = (done_q || (ws_q != '0)) && (ws_q != WLIM);
  assign ready     = sel && !need_wait;

  always_comb begin
    done_d = sel && ready;
    if (sel && !ready) ws_d = ws_q + 1'b1;
    else               ws_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q   <= '0;
      done_q <= 1'b0;
    end else begin
      ws_q   <= ws_d;
      done_q <= done_d;
    end
  end

  // R11: a completed access is never followed by an immediate completion
  p_gap_after_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && ready && (WAIT_CYC > 0)) |=> !ready);
  // R11: a fresh request after an idle cycle is served at once
  p_fresh_zero_wait_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !$past(sel)) |-> ready);
endmodule

// File: rtl/osc_rst_csr.sv
module osc_rst_csr
  import osc_csr_pkg::*;
#(
  parameter int unsigned DROP_CYC        = 6,
  parameter int unsigned WAIT_CYC        = 2,
  parameter int unsigned N_CAUSE         = 7,
  parameter logic [N_CAUSE-1:0] CAUSE_POR = 7'b0000110
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               por_n,
  input  logic               slow_clk,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [3:0]         bus_strb,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_ready,
  input  logic               osc_stable,
  input  logic               lsi_stable,
  input  logic [N_CAUSE-1:0] rst_cause,
  output logic               xo_en,
  output logic               xo_bypass,
  output logic [1:0]         xo_drive,
  output logic               lsi_en
);
  localparam int unsigned CAUSE_LO = DW - N_CAUSE;
  localparam logic [DW-1:0] RD_MASK =
    (DW'((1 << N_CAUSE) - 1) << CAUSE_LO) | DW'(32'h0000_031F);

  ctl_t             ctl_q, ctl_d;
  logic             ctl_ce;
  logic [NLANE-1:0] lane_we;
  logic             wr_fire;
  logic             byp_open;
  logic             rdy_slow;
  logic             xo_rdy_b, lsi_rdy_b;
  logic             flag_clr;
  logic [N_CAUSE-1:0] flags;
  logic [DW-1:0]    rd;

  osc_csr_bus_wait #(.WAIT_CYC(WAIT_CYC)) i_wait (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .ready(bus_ready)
  );

  assign wr_fire = bus_sel && bus_wr && bus_ready;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign lane_we[g] = wr_fire && bus_strb[g];
  end

  assign byp_open = !ctl_q.en && !xo_rdy_b;
  assign ctl_ce   = lane_we[0] || lane_we[1];

  always_comb begin
    ctl_d = ctl_q;
    if (lane_we[0]) begin
      ctl_d.en  = bus_wdata[BIT_EN];
      ctl_d.drv = bus_wdata[DRV_LO +: 2];
      if (byp_open) ctl_d.byp = bus_wdata[BIT_BYP];
    end
    if (lane_we[1]) ctl_d.lsi_en = bus_wdata[BIT_LEN];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= CTL_RST;
    else if (ctl_ce) ctl_q <= ctl_d;
  end

  osc_csr_rdy_timer #(.DROP_CYC(DROP_CYC)) i_timer (
    .slow_clk(slow_clk), .rst_n(rst_n), .en_bus(ctl_q.en),
    .osc_stable(osc_stable), .rdy_slow(rdy_slow)
  );

  osc_csr_sync2 #(.W(2)) i_rdy_sync (
    .clk(clk), .rst_n(rst_n), .d({lsi_stable, rdy_slow}),
    .q({lsi_rdy_b, xo_rdy_b})
  );

  assign flag_clr = lane_we[BIT_CLR / 8] && bus_wdata[BIT_CLR];

  osc_csr_cause #(.N(N_CAUSE), .POR_VAL(CAUSE_POR)) i_cause (
    .clk(clk), .por_n(por_n), .pulse(rst_cause), .clr(flag_clr),
    .flags(flags)
  );

  always_comb begin
    rd = '0;
    rd[BIT_EN]                 = ctl_q.en;
    rd[BIT_RDY]                = xo_rdy_b;
    rd[BIT_BYP]                = ctl_q.byp;
    rd[DRV_LO +: 2]            = ctl_q.drv;
    rd[BIT_LEN]                = ctl_q.lsi_en;
    rd[BIT_LRDY]               = lsi_rdy_b;
    rd[CAUSE_LO +: N_CAUSE]    = flags;
  end

  assign bus_rdata = bus_sel ? rd : '0;
  assign xo_en     = ctl_q.en;
  assign xo_bypass = ctl_q.byp;
  assign xo_drive  = ctl_q.drv;
  assign lsi_en    = ctl_q.lsi_en;

  // R5: bypass is frozen while the oscillator is on or still ready
  p_bypass_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xo_en || xo_rdy_b) |=> $stable(xo_bypass));
  // R9: an unstrobed low lane leaves the oscillator controls alone
  p_lane_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !bus_strb[0]) |=> ($stable(xo_en) && $stable(xo_drive) && $stable(xo_bypass)));
  // R10: reserved positions and the clear bit always read zero
  p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |-> ((bus_rdata & ~RD_MASK) == '0));
  // R2: system reset leaves every control output low
  p_sys_reset_r2: assert property (@(posedge clk)
    !rst_n |-> (!xo_en && !xo_bypass && xo_drive == 2'b00 && !lsi_en));
endmodule

// File: tb/test_osc_rst_csr.sv
module test_osc_rst_csr;
  logic        clk = 1'b0, slow_clk = 1'b0;
  logic        rst_n, por_n;
  logic        bus_sel, bus_wr;
  logic [3:0]  bus_strb;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_ready;
  logic        osc_stable, lsi_stable;
  logic [6:0]  rst_cause;
  logic        xo_en, xo_bypass, lsi_en;
  logic [1:0]  xo_drive;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4  clk = ~clk;
  always #32 slow_clk = ~slow_clk;

  osc_rst_csr i_osc_rst_csr (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .slow_clk(slow_clk),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_strb(bus_strb),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .osc_stable(osc_stable), .lsi_stable(lsi_stable), .rst_cause(rst_cause),
    .xo_en(xo_en), .xo_bypass(xo_bypass), .xo_drive(xo_drive), .lsi_en(lsi_en)
  );

  // each entry: strobes, write data, expected read-back
  typedef struct packed { logic [3:0] strb; logic [31:0] wd; logic [31:0] exp; } vec_t;
  localparam int NV = 8;
  localparam vec_t VT [NV] = '{
    '{4'b1111, 32'hFFFF_FFFF, 32'h0000_011D},
    '{4'b0001, 32'h0000_0000, 32'h0000_0104},
    '{4'b0001, 32'h0000_0000, 32'h0000_0100},
    '{4'b0010, 32'h0000_00FF, 32'h0000_0000},
    '{4'b0001, 32'h0000_01FF, 32'h0000_001D},
    '{4'b1100, 32'h0000_0000, 32'h0000_001D},
    '{4'b0001, 32'h0000_000A, 32'h0000_000C},
    '{4'b0001, 32'h0000_0012, 32'h0000_0010}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [3:0] strb, input logic [31:0] wd,
                      output logic [31:0] rdat, output int waits);
    logic rdy_s;
    int   cyc = 0;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_strb = strb; bus_wdata = wd;
    forever begin
      #1;
      rdy_s = bus_ready;
      rdat  = bus_rdata;
      cyc++;
      @(posedge clk);
      if (rdy_s) break;
    end
    waits = cyc - 1;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_strb = '0;
    repeat (n) @(posedge clk);
  endtask

  task automatic pulse_cause(input logic [6:0] p);
    @(negedge clk); rst_cause = p;
    @(negedge clk); rst_cause = '0;
  endtask

  task automatic apply_reset(input logic with_por);
    @(negedge clk);
    rst_n = 1'b0; if (with_por) por_n = 1'b0;
    repeat (4) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    logic [31:0] rv;
    int w;
    rst_n = 1'b0; por_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_strb = '0; bus_wdata = '0; osc_stable = 1'b0; lsi_stable = 1'b0;
    rst_cause = '0;
    repeat (4) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk); rst_n = 1'b1;

    // R1 power-on value, R11 zero wait after idle
    idle(2);
    xfer(1'b0, 4'h0, 32'h0, rv, w);
    check("R1 por value", rv, 32'h0C00_0000);
    check("R11 fresh access waits", 32'(w), 32'd0);
    check("R1 outputs", {28'h0, xo_en, xo_bypass, xo_drive}, 32'h0);

    // table walk: R3 R4 R5 R8 R9 register behaviour
    idle(1);
    for (int i = 0; i < NV; i++) begin
      xfer(1'b1, VT[i].strb, VT[i].wd, rv, w);
      xfer(1'b0, 4'h0, 32'h0, rv, w);
      check("R3/R4/R5/R9 table read", rv, VT[i].exp);
      check("R11 back-to-back waits", 32'(w), 32'd2);
      if (i == 0) begin
        #1;
        check("R3 R4 ports", {26'h0, lsi_en, xo_en, xo_bypass, xo_drive}, 32'h1F);
      end
    end

    // R10 reserved and read-only bits ignore writes
    idle(1);
    pulse_cause(7'b0001000);
    xfer(1'b1, 4'b1111, 32'hFF7F_FEE2, rv, w);
    xfer(1'b0, 4'h0, 32'h0, rv, w);
    check("R10 reserved/ro ignored", rv, 32'h1000_0000);

    // R7 flag mapping and stickiness
    idle(1);
    pulse_cause(7'b1000001);
    idle(3);
    xfer(1'b0, 4'h0, 32'h0, rv, w);
    check("R7 cause flags", rv, 32'h9200_0000);

    // R9 clear bit in unstrobed lane is ignored
    xfer(1'b1, 4'b0011, 32'h0080_0100, rv, w);
    xfer(1'b0, 4'h0, 32'h0, rv, w);
    check("R9 unstrobed clear", rv, 32'h9200_0100);
    #1; check("R3 lsi_en port", {31'h0, lsi_en}, 32'h1);

    // R8 set wins over simultaneous clear
    idle(2);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_strb = 4'b0100; bus_wdata = 32'h0080_0000;
    rst_cause = 7'b1000000;
    @(posedge clk); #1;
    bus_sel = 1'b0; rst_cause = '0;
    idle(2);
    xfer(1'b0, 4'h0, 32'h0, rv, w);
    check("R8 set wins clear", rv, 32'h8000_0100);

    // R2 system reset keeps flags
    idle(1);
    pulse_cause(7'b0000100);
    apply_reset(1'b0);
    idle(2);
    xfer(1'b0, 4'h0, 32'h0, rv, w);
    check("R2 sys reset", rv, 32'h8800_0000);

    // R6 ready timing and R5 lock while ready
    osc_stable = 1'b1;
    idle(1);
    xfer(1'b1, 4'b0001, 32'h1, rv, w);
    idle(80);
    xfer(1'b0, 4'h0, 32'h0, rv, w);
    check("R6 ready while enabled", rv, 32'h8800_0003);
    xfer(1'b1, 4'b0001, 32'h0, rv, w);
    idle(24);
    xfer(1'b1, 4'b0001, 32'h4, rv, w);
    xfer(1'b0, 4'h0, 32'h0, rv, w);
    check("R6 ready held / R5 bypass locked", rv, 32'h8800_0002);
    idle(112);
    xfer(1'b0, 4'h0, 32'h0, rv, w);
    check("R6 ready dropped", rv, 32'h8800_0000);
    xfer(1'b1, 4'b0001, 32'h4, rv, w);
    xfer(1'b0, 4'h0, 32'h0, rv, w);
    check("R5 bypass unlocked", rv, 32'h8800_0004);
    #1; check("R5 bypass port", {31'h0, xo_bypass}, 32'h1);

    // R12 internal ready
    lsi_stable = 1'b1;
    idle(5);
    xfer(1'b0, 4'h0, 32'h0, rv, w);
    check("R12 lsi ready", rv, 32'h8800_0204);

    // R1 power-on again
    idle(1);
    apply_reset(1'b1);
    lsi_stable = 1'b0;
    idle(4);
    xfer(1'b0, 4'h0, 32'h0, rv, w);
    check("R1 por again", rv, 32'h0C00_0000);

    idle(1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule